// File: doc/BRIEF.md
# Timer Compare Output Unit

This block combines a free-running up-counter, one compare register and a single output latch that drives a port pin. When compare mode is on, the latch becomes a set/reset element. A counting step that finds the timer equal to the compare value sets the pin high. The wrap of the counter from all-ones to zero clears the pin. The bus path to the latch is cut off for as long as the mode stays on.

Every match also sets a sticky event flag. Software clears the flag by writing one to it, and an enable bit gates the flag onto the interrupt output. A plain single-cycle write port loads the control bits, the compare value, the counter and the latch. A registered read port returns those registers, the event flag and the level seen on the external pin.

When compare mode is off, the latch is an ordinary port latch that software writes. Turning the mode on or off leaves the latch value as it is.

Top module: `tcmp_unit`

## Requirements
- R1: After a synchronous active-high reset the pin output, the interrupt output, the control bits, the compare value, the counter and the event flag are all zero.
- R2: The counter rises by one on every clock edge while the run bit (control bit 2) is 1, and holds otherwise. A write to the counter (address 2) loads wr_data at that edge, and the load overrides counting.
- R3: A counting step taken from the all-ones value wraps the counter to zero. With compare mode on (control bit 0), the same edge clears the pin latch.
- R4: With compare mode on, a counting step taken while the counter equals the compare value sets the pin latch at that edge. The pin is therefore high from the cycle in which the counter shows compare+1.
- R5: When a match and a wrap fall on the same edge, the latch is cleared.
- R6: While compare mode is on, writes to the latch (address 3) are ignored.
- R7: While compare mode is off, a latch write stores wr_data[0], and matches and wraps leave the latch alone. Changing the mode leaves the latch value unchanged.
- R8: Every counting step that finds a match sets the event flag, whatever the mode. The flag stays set until a write to address 4 with wr_data[0]=1. A match on the same edge as such a clear keeps the flag set.
- R9: irq_o is high exactly when the event flag is set and the interrupt-enable bit (control bit 1) is 1.
- R10: rd_data shows, one edge after rd_addr is applied, the register that rd_addr selects: 0 control in bits 2:0, 1 compare, 2 counter, 3 latch in bit 0, 4 event flag in bit 0, 5 level of pin_in in bit 0. Any other address reads zero, and control write bits above bit 2 are discarded.
- R11: A newly written compare value is used for matching from the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | CNT_W | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | CNT_W | Registered read data |
| pin_in | input | 1 | Level sensed on the external pin |
| cmp_pin_o | output | 1 | Compare latch driving the pin |
| irq_o | output | 1 | Gated compare-event interrupt |

## Verification
The bench builds the unit with its default 16-bit counter. Because the counter can be loaded directly, values a few counts below all-ones are reached in a handful of cycles, so wraps and matches at the top of the range are exercised without sweeping all 65,536 states. A compare value of all-ones places a match and a wrap on the same edge, which checks the clear-wins rule. Counting with compare mode off shows that matches and wraps leave a software-written latch unchanged.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;
  typedef enum logic [2:0] {
    A_CTRL = 3'd0,
    A_CMP  = 3'd1,
    A_TMR  = 3'd2,
    A_PORT = 3'd3,
    A_STAT = 3'd4,
    A_PIN  = 3'd5
  } reg_addr_e;

  localparam int CTRL_MODE = 0;
  localparam int CTRL_IEN  = 1;
  localparam int CTRL_RUN  = 2;
  localparam int CTRL_W    = 3;
endpackage

// File: rtl/tcmp_timer.sv
module tcmp_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             step_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  assign step_o = run_i && !load_i;
  assign ovf_o  = step_o && (cnt_q == CNT_MAX);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (run_i)  cnt_q <= cnt_q + 1'b1;
  end

  assert_wrap_zero_R3: assert property (@(posedge clk) disable iff (rst)
    ovf_o |=> (cnt_q == '0));
  assert_load_wins_R2: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (cnt_q == $past(load_val_i)));
  assert_hold_stopped_R2: assert property (@(posedge clk) disable iff (rst)
    (!run_i && !load_i) |=> $stable(cnt_q));
endmodule

// File: rtl/tcmp_compare.sv
module tcmp_compare #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             clr_i,
  output logic             match_o,
  output logic             flag_o
);
  logic flag_q;

  assign match_o = step_i && (cnt_i == cmp_i);
  assign flag_o  = flag_q;

  always_ff @(posedge clk) begin
    if (rst)          flag_q <= 1'b0;
    else if (match_o) flag_q <= 1'b1;
    else if (clr_i)   flag_q <= 1'b0;
  end

  assert_flag_set_R8: assert property (@(posedge clk) disable iff (rst)
    match_o |=> flag_q);
  assert_flag_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !match_o) |=> !flag_q);
  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr_i) |=> flag_q);
endmodule

// File: rtl/tcmp_port_latch.sv
module tcmp_port_latch (
  input  logic clk,
  input  logic rst,
  input  logic mode_i,
  input  logic set_i,
  input  logic clr_i,
  input  logic wr_i,
  input  logic wr_bit_i,
  output logic q_o
);
  logic q;

  assign q_o = q;

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= 1'b0;
    end else if (mode_i) begin
      if (clr_i)      q <= 1'b0;
      else if (set_i) q <= 1'b1;
    end else if (wr_i) begin
      q <= wr_bit_i;
    end
  end

  assert_wrap_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (mode_i && clr_i) |=> !q);
  assert_match_sets_R4: assert property (@(posedge clk) disable iff (rst)
    (mode_i && set_i && !clr_i) |=> q);
  assert_bus_cut_R6: assert property (@(posedge clk) disable iff (rst)
    (mode_i && !set_i && !clr_i) |=> $stable(q));
  assert_bus_write_R7: assert property (@(posedge clk) disable iff (rst)
    (!mode_i && wr_i) |=> (q == $past(wr_bit_i)));
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!mode_i && !wr_i) |=> $stable(q));
endmodule

// File: rtl/tcmp_unit.sv
module tcmp_unit #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [2:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  input  logic             pin_in,
  output logic             cmp_pin_o,
  output logic             irq_o
);
  import tcmp_pkg::*;

  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  cmp_q;
  logic [CNT_W-1:0]  cnt;
  logic              step, ovf, match, flag, latch_q;
  logic              wr_ctrl, wr_cmp, wr_tmr, wr_port, clr_flag;
  logic [CNT_W-1:0]  rd_next, rd_q;

  assign wr_ctrl  = wr_en && (wr_addr == A_CTRL);
  assign wr_cmp   = wr_en && (wr_addr == A_CMP);
  assign wr_tmr   = wr_en && (wr_addr == A_TMR);
  assign wr_port  = wr_en && (wr_addr == A_PORT);
  assign clr_flag = wr_en && (wr_addr == A_STAT) && wr_data[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      cmp_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wr_data[CTRL_W-1:0];
      if (wr_cmp)  cmp_q  <= wr_data;
    end
  end

  tcmp_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .run_i      (ctrl_q[CTRL_RUN]),
    .load_i     (wr_tmr),
    .load_val_i (wr_data),
    .cnt_o      (cnt),
    .step_o     (step),
    .ovf_o      (ovf)
  );

  tcmp_compare #(.CNT_W(CNT_W)) u_compare (
    .clk     (clk),
    .rst     (rst),
    .step_i  (step),
    .cnt_i   (cnt),
    .cmp_i   (cmp_q),
    .clr_i   (clr_flag),
    .match_o (match),
    .flag_o  (flag)
  );

  tcmp_port_latch u_latch (
    .clk      (clk),
    .rst      (rst),
    .mode_i   (ctrl_q[CTRL_MODE]),
    .set_i    (match),
    .clr_i    (ovf),
    .wr_i     (wr_port),
    .wr_bit_i (wr_data[0]),
    .q_o      (latch_q)
  );

  always_comb begin
    rd_next = '0;
    case (rd_addr)
      A_CTRL:  rd_next[CTRL_W-1:0] = ctrl_q;
      A_CMP:   rd_next = cmp_q;
      A_TMR:   rd_next = cnt;
      A_PORT:  rd_next[0] = latch_q;
      A_STAT:  rd_next[0] = flag;
      A_PIN:   rd_next[0] = pin_in;
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_next;
  end

  assign rd_data   = rd_q;
  assign cmp_pin_o = latch_q;
  assign irq_o     = flag && ctrl_q[CTRL_IEN];

  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && !wr_data[CTRL_IEN]) |=> !irq_o);
  assert_cmp_immediate_R11: assert property (@(posedge clk) disable iff (rst)
    wr_cmp |=> (cmp_q == $past(wr_data)));
endmodule

// File: tb/tcmp_unit_tb.sv
module tcmp_unit_tb;
  localparam int CNT_W = 16;
  localparam int NVEC  = 6;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wr_en = 1'b0;
  logic [2:0]       wr_addr = '0;
  logic [CNT_W-1:0] wr_data = '0;
  logic [2:0]       rd_addr = '0;
  logic [CNT_W-1:0] rd_data;
  logic             pin_in = 1'b0;
  logic             cmp_pin_o;
  logic             irq_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tcmp_unit #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pin_in(pin_in),
    .cmp_pin_o(cmp_pin_o), .irq_o(irq_o)
  );

  // {write addr, write data, read addr, expected read}
  localparam logic [37:0] VEC [NVEC] = '{
    {3'd1, 16'hBEEF, 3'd1, 16'hBEEF},
    {3'd2, 16'h1234, 3'd2, 16'h1234},
    {3'd0, 16'h0003, 3'd0, 16'h0003},
    {3'd0, 16'hFFF8, 3'd0, 16'h0000},
    {3'd1, 16'h0000, 3'd1, 16'h0000},
    {3'd7, 16'hAAAA, 3'd6, 16'h0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [CNT_W-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [CNT_W-1:0] exp);
    rd_addr = a;
    @(negedge clk);
    chk(req, {16'h0, rd_data}, {16'h0, exp});
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    // R1 reset state
    chk("R1 pin", {31'h0, cmp_pin_o}, 32'h0);
    chk("R1 irq", {31'h0, irq_o}, 32'h0);
    rd_chk("R1 ctrl", 3'd0, 16'h0);
    rd_chk("R1 cmp", 3'd1, 16'h0);
    rd_chk("R1 tmr", 3'd2, 16'h0);
    rd_chk("R1 flag", 3'd4, 16'h0);

    // R10 table of write/readback vectors
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][37:35], VEC[i][34:19]);
      rd_chk("R10 table", VEC[i][18:16], VEC[i][15:0]);
    end
    pin_in = 1'b1;
    rd_chk("R10 pin high", 3'd5, 16'h1);
    pin_in = 1'b0;
    rd_chk("R10 pin low", 3'd5, 16'h0);

    // R2 counting for a known number of edges
    wr(3'd2, 16'h0100);
    wr(3'd0, 16'h0004);
    tick(9);
    wr(3'd0, 16'h0000);
    rd_chk("R2 count", 3'd2, 16'h010A);
    tick(4);
    rd_chk("R2 hold", 3'd2, 16'h010A);

    // R4/R11 match sets the pin
    wr(3'd1, 16'h0010);
    wr(3'd2, 16'h000D);
    wr(3'd0, 16'h0005);
    tick(3);
    chk("R4 before match", {31'h0, cmp_pin_o}, 32'h0);
    tick(1);
    chk("R4 after match", {31'h0, cmp_pin_o}, 32'h1);
    chk("R9 irq disabled", {31'h0, irq_o}, 32'h0);
    rd_chk("R8 flag set", 3'd4, 16'h1);

    // R6 bus write ignored in compare mode
    wr(3'd3, 16'h0000);
    chk("R6 pin kept", {31'h0, cmp_pin_o}, 32'h1);
    rd_chk("R6 latch kept", 3'd3, 16'h1);

    // R3 wrap clears the pin, load overrides counting (R2)
    wr(3'd2, 16'hFFFE);
    tick(1);
    chk("R3 before wrap", {31'h0, cmp_pin_o}, 32'h1);
    tick(1);
    chk("R3 after wrap", {31'h0, cmp_pin_o}, 32'h0);

    // R5 match and wrap together, R7 mode change keeps latch
    wr(3'd0, 16'h0000);
    wr(3'd3, 16'h0001);
    chk("R7 bus write", {31'h0, cmp_pin_o}, 32'h1);
    wr(3'd1, 16'hFFFF);
    wr(3'd2, 16'hFFFD);
    wr(3'd4, 16'h0001);
    rd_chk("R8 flag cleared", 3'd4, 16'h0);
    wr(3'd0, 16'h0005);
    tick(1);
    chk("R7 mode on keeps latch", {31'h0, cmp_pin_o}, 32'h1);
    tick(1);
    chk("R5 before tie", {31'h0, cmp_pin_o}, 32'h1);
    tick(1);
    chk("R5 tie clears", {31'h0, cmp_pin_o}, 32'h0);
    wr(3'd0, 16'h0000);
    rd_chk("R8 flag on tie", 3'd4, 16'h1);

    // R7 mode off: match and wrap leave latch alone, R8 flag still set
    wr(3'd4, 16'h0001);
    wr(3'd3, 16'h0001);
    wr(3'd2, 16'hFFFD);
    wr(3'd0, 16'h0004);
    tick(4);
    chk("R7 wrap no effect", {31'h0, cmp_pin_o}, 32'h1);
    wr(3'd0, 16'h0000);
    rd_chk("R8 flag mode off", 3'd4, 16'h1);

    // R9 interrupt gating and clear
    wr(3'd0, 16'h0002);
    chk("R9 irq on", {31'h0, irq_o}, 32'h1);
    wr(3'd4, 16'h0001);
    chk("R9 irq off after clear", {31'h0, irq_o}, 32'h0);

    // R8 set wins over clear on the same edge
    wr(3'd1, 16'h0020);
    wr(3'd2, 16'h001F);
    wr(3'd0, 16'h0006);
    tick(1);
    wr(3'd4, 16'h0001);
    chk("R8 set wins", {31'h0, irq_o}, 32'h1);
    wr(3'd0, 16'h0000);
    chk("R9 irq gated off", {31'h0, irq_o}, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule